// File: doc/BRIEF.md
# Ticket-Based Mutual-Exclusion Lock

This block arbitrates one shared resource among a set of requesters and serves them strictly in the order in which they asked. It keeps two counters: the ticket to hand out next, and the ticket now entitled to the resource. A requester raises its acquire line for one cycle and is given the current ticket; the ticket counter moves past it in the same cycle. The block stores the ticket for that port and drives the port's grant line as long as the stored ticket matches the entitled one. The requester therefore learns about its turn without any polling.

When the holder is finished it pulses its release line. The entitled counter then advances and the grant passes to whichever port holds the following ticket. Requests that arrive in the same cycle are queued in ascending port order. The counters wrap, and because grants depend only on equality, the wrap does not disturb the order. Misused releases are ignored and reported on an error line. Repeat acquires from a port that already owns a ticket are dropped without a report.

Top module: `ticket_lock`

## Requirements
- R1: After reset no grant line, no pending line and no error line is high, and both counters start at zero, so the first port to acquire is granted in the cycle after its request.
- R2: An acquire accepted while no other port holds a ticket raises that port's grant and pending lines in the cycle after the request edge.
- R3: Ports that acquire in different cycles are granted in the order of those cycles.
- R4: Ports that acquire in the same cycle receive consecutive tickets in ascending port index, so index 0 is served before index 1, and so on.
- R5: A release from the granted port clears its pending line and, in the cycle after the release edge, grants the port holding the next ticket, or no port if none waits.
- R6: At most one grant line is high in any cycle.
- R7: A granted port keeps its grant until it releases.
- R8: A release from a port that is not granted changes no grant or pending line and raises relErr in the following cycle.
- R9: An acquire from a port whose pending line is high is ignored: no extra ticket is issued, and after its single turn the port is not granted again.
- R10: The ticket counters wrap modulo 2^TKT_W, where TKT_W = clog2(NUM_PORTS+1), and the service order stays correct across many wraps.
- R11: relErr is high only in the cycle after a bad release and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| acqReq | input | NUM_PORTS | One-cycle acquire request per port |
| relReq | input | NUM_PORTS | One-cycle release request per port |
| granted | output | NUM_PORTS | High while the port owns the lock |
| pending | output | NUM_PORTS | High while the port holds a ticket (waiting or granted) |
| relErr | output | 1 | One-cycle flag after a release from a non-holder |

## Verification
The hardest case to reach from the ports is a queue of waiting tickets that straddles the point where the counters wrap to zero. A direct test would need many acquire and release rounds in a fixed order. The bench instead drives a long pseudo-random stream of acquires, correct releases and stray releases. This carries the counters through several wraps while the queue stays partly full. A reference queue in the bench predicts every grant, pending and error value after each edge, so any ordering slip near a wrap shows up at once.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;

  // Strobes from the control path to the counter/ticket datapath
  typedef struct packed {
    logic anyTake;   // at least one acquire accepted this cycle
    logic advance;   // holder released, move the serving counter
    logic badRel;    // release seen from a port that is not granted
  } lockStrobe_t;

endpackage

// File: rtl/ticket_lock_ctrl.sv
module ticket_lock_ctrl
  import ticket_lock_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] acqReq,
  input  logic [NUM_PORTS-1:0] relReq,
  input  logic [NUM_PORTS-1:0] pending,
  input  logic [NUM_PORTS-1:0] granted,
  output logic [NUM_PORTS-1:0] acqTake,
  output logic [NUM_PORTS-1:0] relTake,
  output lockStrobe_t          strobe,
  output logic                 relErr
);

  // A port with a ticket outstanding cannot take another one
  always_comb begin
    acqTake        = acqReq & ~pending;
    relTake        = relReq & granted;
    strobe.anyTake = |acqTake;
    strobe.advance = |relTake;
    strobe.badRel  = |(relReq & ~granted);
  end

  always_ff @(posedge clk) begin
    if (!rstN) relErr <= 1'b0;
    else       relErr <= strobe.badRel;
  end

endmodule

// File: rtl/ticket_lock_datapath.sv
module ticket_lock_datapath
  import ticket_lock_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TKT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] acqTake,
  input  logic [NUM_PORTS-1:0] relTake,
  input  lockStrobe_t          strobe,
  output logic [NUM_PORTS-1:0] pending,
  output logic [NUM_PORTS-1:0] granted
);

  logic [TKT_W-1:0] nextTkt;
  logic [TKT_W-1:0] nowServing;
  logic [TKT_W-1:0] offs [NUM_PORTS];
  logic [TKT_W-1:0] runSum;

  // Ascending port order: each accepted port takes the count of
  // accepted lower-index ports as its offset from nextTkt.
  always_comb begin
    runSum = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      offs[i] = runSum;
      if (acqTake[i]) runSum = runSum + TKT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextTkt    <= '0;
      nowServing <= '0;
    end else begin
      if (strobe.anyTake) nextTkt    <= nextTkt + runSum;
      if (strobe.advance) nowServing <= nowServing + TKT_W'(1);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [TKT_W-1:0] tkt;
    logic             held;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tkt  <= '0;
        held <= 1'b0;
      end else if (acqTake[p]) begin
        tkt  <= nextTkt + offs[p];
        held <= 1'b1;
      end else if (relTake[p]) begin
        held <= 1'b0;
      end
    end

    assign pending[p] = held;
    assign granted[p] = held && (tkt == nowServing);
  end

endmodule

// File: rtl/ticket_lock.sv
module ticket_lock
  import ticket_lock_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] acqReq,
  input  logic [NUM_PORTS-1:0] relReq,
  output logic [NUM_PORTS-1:0] granted,
  output logic [NUM_PORTS-1:0] pending,
  output logic                 relErr
);

  // Enough ticket values to keep one per port distinct
  localparam int TKT_W = $clog2(NUM_PORTS + 1);

  logic [NUM_PORTS-1:0] acqTake;
  logic [NUM_PORTS-1:0] relTake;
  lockStrobe_t          strobe;

  ticket_lock_ctrl #(.NUM_PORTS(NUM_PORTS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .acqReq  (acqReq),
    .relReq  (relReq),
    .pending (pending),
    .granted (granted),
    .acqTake (acqTake),
    .relTake (relTake),
    .strobe  (strobe),
    .relErr  (relErr)
  );

  ticket_lock_datapath #(.NUM_PORTS(NUM_PORTS), .TKT_W(TKT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .acqTake (acqTake),
    .relTake (relTake),
    .strobe  (strobe),
    .pending (pending),
    .granted (granted)
  );

endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] acqReq,
  input logic [NUM_PORTS-1:0] relReq,
  input logic [NUM_PORTS-1:0] granted,
  input logic [NUM_PORTS-1:0] pending,
  input logic                 relErr
);

  // R6
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(granted));

  // R7
  holder_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|granted) && !(|(relReq & granted))) |=> (granted == $past(granted)));

  // R8
  bad_rel_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(relReq & ~granted)) |=> relErr);

  // R11
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    relErr |-> $past(|(relReq & ~granted)));

  // R5
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(pending) & ~pending) & ~($past(relReq) & $past(granted))) == '0));

  // R9
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(acqReq & pending & ~(relReq & granted))) |=> (|(pending & $past(acqReq & pending))));

endmodule

bind ticket_lock ticket_lock_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .acqReq  (acqReq),
  .relReq  (relReq),
  .granted (granted),
  .pending (pending),
  .relErr  (relErr)
);

// File: tb/test_ticket_lock.sv
module test_ticket_lock;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] acqReq;
  logic [NP-1:0] relReq;
  logic [NP-1:0] granted;
  logic [NP-1:0] pending;
  logic          relErr;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  // Reference model: arrival queue of port indices
  int            qArr [NP];
  int            qCnt = 0;
  logic [NP-1:0] pendModel = '0;

  always #2.5 clk = ~clk;

  ticket_lock #(.NUM_PORTS(NP)) i_ticket_lock (
    .clk     (clk),
    .rstN    (rstN),
    .acqReq  (acqReq),
    .relReq  (relReq),
    .granted (granted),
    .pending (pending),
    .relErr  (relErr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] headMask();
    return (qCnt > 0) ? (NP'(1) << qArr[0]) : '0;
  endfunction

  // Apply one cycle of requests, advance the model, compare all outputs
  task automatic doCycle(input logic [NP-1:0] acq, input logic [NP-1:0] rel, input string tag);
    logic [NP-1:0] gBefore, validRel, accMask;
    logic          bad;
    gBefore  = headMask();
    validRel = rel & gBefore;
    bad      = |(rel & ~gBefore);
    accMask  = acq & ~pendModel;
    if (validRel != '0) begin
      for (int k = 0; k < NP - 1; k++) qArr[k] = qArr[k+1];
      qCnt--;
    end
    for (int i = 0; i < NP; i++) begin
      if (accMask[i]) begin
        qArr[qCnt] = i;
        qCnt++;
      end
    end
    pendModel = (pendModel & ~validRel) | accMask;
    acqReq = acq;
    relReq = rel;
    step();
    acqReq = '0;
    relReq = '0;
    check({tag, " granted"}, 32'(granted), 32'(headMask()));
    check({tag, " pending"}, 32'(pending), 32'(pendModel));
    check({tag, " relErr"},  32'(relErr),  32'(bad));
    check("R6 single owner", 32'($countones(granted) <= 1), 32'd1);
  endtask

  task automatic drain();
    while (qCnt > 0) doCycle('0, headMask(), "R5");
  endtask

  task automatic testReset();
    rstN   = 1'b0;
    acqReq = '0;
    relReq = '0;
    repeat (3) step();
    rstN = 1'b1;
    check("R1 granted", 32'(granted), 32'd0);
    check("R1 pending", 32'(pending), 32'd0);
    check("R1 relErr",  32'(relErr),  32'd0);
    doCycle(4'b0001, '0, "R1");
    check("R1 first grant", 32'(granted), 32'h1);
    drain();
  endtask

  task automatic testSingle();
    doCycle(4'b0100, '0, "R2");
    check("R2 grant port2", 32'(granted), 32'h4);
    doCycle('0, 4'b0100, "R5");
    check("R5 freed", 32'(granted), 32'h0);
  endtask

  task automatic testArrival();
    doCycle(4'b1000, '0, "R3");
    doCycle(4'b0001, '0, "R3");
    doCycle(4'b0010, '0, "R3");
    check("R3 first", 32'(granted), 32'h8);
    doCycle('0, 4'b1000, "R5");
    check("R3 second", 32'(granted), 32'h1);
    doCycle('0, 4'b0001, "R5");
    check("R3 third", 32'(granted), 32'h2);
    drain();
  endtask

  task automatic testSimultaneous();
    doCycle(4'b1111, '0, "R4");
    check("R4 idx0", 32'(granted), 32'h1);
    doCycle('0, 4'b0001, "R4");
    check("R4 idx1", 32'(granted), 32'h2);
    doCycle('0, 4'b0010, "R4");
    check("R4 idx2", 32'(granted), 32'h4);
    doCycle('0, 4'b0100, "R4");
    check("R4 idx3", 32'(granted), 32'h8);
    drain();
  endtask

  task automatic testBadRelease();
    doCycle(4'b0001, '0, "R8");
    doCycle(4'b0010, '0, "R8");
    doCycle('0, 4'b0110, "R8");
    check("R8 flag", 32'(relErr), 32'd1);
    check("R7 holder kept", 32'(granted), 32'h1);
    doCycle('0, '0, "R11");
    check("R11 flag drop", 32'(relErr), 32'd0);
    drain();
  endtask

  task automatic testReacquire();
    doCycle(4'b0001, '0, "R9");
    doCycle(4'b0010, '0, "R9");
    doCycle(4'b0011, '0, "R9");
    doCycle('0, 4'b0001, "R9");
    check("R9 port1 turn", 32'(granted), 32'h2);
    doCycle('0, 4'b0010, "R9");
    check("R9 no extra ticket", 32'(granted), 32'h0);
    check("R9 no pending", 32'(pending), 32'h0);
  endtask

  task automatic testWrap();
    logic [7:0] lfsr = 8'hA5;
    for (int n = 0; n < 120; n++) begin
      logic [NP-1:0] rel;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rel  = lfsr[5] ? headMask() : (lfsr[6] ? lfsr[7:4] : '0);
      doCycle(lfsr[3:0], rel, "R10");
    end
    drain();
  endtask

  initial begin
    testReset();
    testSingle();
    testArrival();
    testSimultaneous();
    testBadRelease();
    testReacquire();
    testWrap();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule